// File: doc/BRIEF.md
# Banked Memory Interlock Arbiter

This block decides, slot by slot, which requesting section may start an access on one of several independent memory banks. The four requesters are a DMA synchronizer group, an I/O processor and two processors. Time is a repeating major cycle of eight one-clock slots, and each requester owns one slot in it. A requester raises its request with a bank index. In its own slot it receives either a grant or a lockout in the same clock.

A granted bank stays unavailable for the rest of that major cycle. A requester that hits a busy bank is locked out and is expected to retry in its slot of the next major cycle. A lockout also leaves a reservation on that bank. While the reservation stands, lower-priority requesters cannot start on the bank even when it is free, so a high-priority retry cannot be starved. The data path, the storage array and the full-address decoding are not part of the block.

Top module: `bank_interlock_arb`

## Requirements
- R1: `slot_o` is 0 while reset is asserted and in the first clock after release. It then advances by one each clock and wraps from 7 to 0, so one major cycle is eight clocks.
- R2: Requester r (0 = DMA, 1 = I/O, 2 = processor 0, 3 = processor 1) is served only while `slot_o` equals 2r. Its grant or lockout appears in that same clock. In any other slot, or when its request is low, both of its outputs are 0. At most one of the eight output bits is high in any clock.
- R3: A request that is served, for an in-range bank that is neither busy nor reserved, is granted.
- R4: After a grant to bank b, `busy_o[b]` is high for exactly the next seven clocks. A request for b in the same slot of the next major cycle may be granted again.
- R5: A request for a busy bank is locked out. No bank is granted twice within any eight consecutive clocks.
- R6: A locked-out request for an in-range bank reserves that bank when the bank has no reservation, or when its reservation belongs to a lower-priority requester (a higher index). A DMA retry of the same bank in the next major cycle is always granted.
- R7: While bank b is reserved, a lower-priority requester is locked out of b even when b is not busy. The owner, or a higher-priority requester, is granted b whenever b is not busy.
- R8: A grant to the reservation owner removes the reservation. After that, lower-priority requesters are again granted the bank once it is free.
- R9: Requests in the slots of one major cycle that name pairwise different free banks are all granted.
- R10: A bank index of `NUM_BANKS` or more is locked out. It changes no busy or reservation state.
- R11: Asserting `rst_ni` clears all busy and reservation state at once. After release, every bank can be granted in the first major cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one slot per clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request per requester, index = priority rank (0 highest) |
| bank_i | input | 4*BANK_W | Bank index per requester, requester r in bits [r*BANK_W +: BANK_W] |
| grant_o | output | 4 | Grant per requester, valid in its own slot |
| lockout_o | output | 4 | Lockout per requester, valid in its own slot |
| slot_o | output | 3 | Current slot within the major cycle |
| busy_o | output | NUM_BANKS | Bank-unavailable flags |

## Verification
The bench builds the arbiter with `NUM_BANKS` = 6. With that value the 3-bit bank field has two codes, 6 and 7, that name no bank, so the out-of-range lockout can be reached. A random bank choice also collides often, which exercises busy lockouts, reservation hand-over between priorities and retries that are blocked by a reservation. A drain phase lets only the pending retries run, which shows that every lockout is granted in the end.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  localparam int SLOTS       = 8;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int NUM_REQ     = 4;
  localparam int REQ_W       = $clog2(NUM_REQ);
  localparam int SLOT_STRIDE = SLOTS / NUM_REQ;
  localparam int BUSY_SPAN   = SLOTS - 1;
  localparam int CNT_W       = $clog2(SLOTS);

  // Lower index wins a reservation contest
  typedef enum logic [REQ_W-1:0] {
    REQ_DMA  = 2'd0,
    REQ_IO   = 2'd1,
    REQ_CPU0 = 2'd2,
    REQ_CPU1 = 2'd3
  } req_id_e;
endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer
  import bank_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              owned_o,
  output logic [REQ_W-1:0]  owner_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_q + 1'b1;
  end

  assign slot_o  = slot_q;
  assign owned_o = (slot_q % SLOT_W'(SLOT_STRIDE)) == '0;
  assign owner_o = REQ_W'(slot_q / SLOT_W'(SLOT_STRIDE));
endmodule

// File: rtl/arb_bank_busy.sv
module arb_bank_busy
  import bank_arb_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int BANK_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic [BANK_W-1:0]    set_bank_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q <= '0;
      else if (set_en_i && (set_bank_i == BANK_W'(b)))
        cnt_q <= CNT_W'(BUSY_SPAN);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o[b] = |cnt_q;
  end
endmodule

// File: rtl/arb_bank_reserve.sv
module arb_bank_reserve
  import bank_arb_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int BANK_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_en_i,
  input  logic              grant_en_i,
  input  logic [REQ_W-1:0]  req_id_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              hit_valid_o,
  output logic [REQ_W-1:0]  hit_owner_o
);
  logic [NUM_BANKS-1:0]            valid_q;
  logic [NUM_BANKS-1:0][REQ_W-1:0] owner_q;

  assign hit_valid_o = valid_q[bank_i];
  assign hit_owner_o = owner_q[bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_res
    logic sel, take, drop;
    assign sel  = bank_i == BANK_W'(b);
    // Higher priority (lower id) displaces a weaker holder
    assign take = sel && lock_en_i && (!valid_q[b] || (req_id_i < owner_q[b]));
    assign drop = sel && grant_en_i && valid_q[b] && (owner_q[b] == req_id_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[b] <= 1'b0;
        owner_q[b] <= '0;
      end else if (drop) begin
        valid_q[b] <= 1'b0;
      end else if (take) begin
        valid_q[b] <= 1'b1;
        owner_q[b] <= req_id_i;
      end
    end
  end
endmodule

// File: rtl/bank_interlock_arb.sv
module bank_interlock_arb
  import bank_arb_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*BANK_W-1:0] bank_i,
  output logic [NUM_REQ-1:0]        grant_o,
  output logic [NUM_REQ-1:0]        lockout_o,
  output logic [SLOT_W-1:0]         slot_o,
  output logic [NUM_BANKS-1:0]      busy_o
);
  logic              owned;
  logic [REQ_W-1:0]  owner;
  logic [BANK_W-1:0] cur_bank, safe_bank;
  logic              active, in_range, res_valid, res_block, win;
  logic [REQ_W-1:0]  res_owner;

  arb_slot_timer u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_o  (slot_o),
    .owned_o (owned),
    .owner_o (owner)
  );

  assign cur_bank  = bank_i[owner*BANK_W +: BANK_W];
  assign active    = owned && req_i[owner];
  assign in_range  = int'(cur_bank) < NUM_BANKS;
  assign safe_bank = in_range ? cur_bank : '0;
  // A stronger requester's earlier lockout fences this bank
  assign res_block = res_valid && (res_owner < owner);
  assign win       = active && in_range && !busy_o[safe_bank] && !res_block;

  assign grant_o   = win ? (NUM_REQ'(1) << owner) : '0;
  assign lockout_o = (active && !win) ? (NUM_REQ'(1) << owner) : '0;

  arb_bank_busy #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (win),
    .set_bank_i (safe_bank),
    .busy_o     (busy_o)
  );

  arb_bank_reserve #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_en_i   (active && !win && in_range),
    .grant_en_i  (win),
    .req_id_i    (owner),
    .bank_i      (safe_bank),
    .hit_valid_o (res_valid),
    .hit_owner_o (res_owner)
  );
endmodule

// File: rtl/bank_arb_chk.sv
module bank_arb_chk
  import bank_arb_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_REQ-1:0]        req_i,
  input logic [NUM_REQ*BANK_W-1:0] bank_i,
  input logic [NUM_REQ-1:0]        grant_o,
  input logic [NUM_REQ-1:0]        lockout_o,
  input logic [SLOT_W-1:0]         slot_o,
  input logic [NUM_BANKS-1:0]      busy_o
);
  logic [NUM_BANKS-1:0][CNT_W-1:0] gap_q;
  logic [3:0]                      warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 4'd8) warm_q <= warm_q + 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++)
        if (grant_o[r] && (int'(bank_i[r*BANK_W +: BANK_W]) == b)) hit = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          gap_q[b] <= CNT_W'(BUSY_SPAN);
      else if (hit)                         gap_q[b] <= '0;
      else if (gap_q[b] != CNT_W'(BUSY_SPAN)) gap_q[b] <= gap_q[b] + 1'b1;
    end

    AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[b] == (gap_q[b] != CNT_W'(BUSY_SPAN))); // R4
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    logic [BANK_W-1:0] bnk;
    assign bnk = bank_i[r*BANK_W +: BANK_W];

    AST_NO_DOUBLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[r] |-> (gap_q[bnk] == CNT_W'(BUSY_SPAN))); // R5

    AST_RANGE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_o == SLOT_W'(r*SLOT_STRIDE) && req_i[r] && int'(bnk) >= NUM_BANKS)
        |-> lockout_o[r]); // R10
  end

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> slot_o == $past(slot_o) + 1'b1); // R1

  AST_ONE_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, lockout_o})); // R2

  AST_IDLE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o[0] |-> (grant_o == '0 && lockout_o == '0)); // R2

  AST_DMA_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 4'd8 && req_i[0] && $past(lockout_o[0], 8)
     && bank_i[BANK_W-1:0] == $past(bank_i[BANK_W-1:0], 8)
     && int'(bank_i[BANK_W-1:0]) < NUM_BANKS) |-> grant_o[0]); // R6
endmodule

bind bank_interlock_arb bank_arb_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/bank_interlock_arb_test.sv
module bank_interlock_arb_test;
  localparam int NB = 6;
  localparam int BW = 3;
  localparam int NR = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NR-1:0]   req = '0;
  logic [NR*BW-1:0] bank = '0;
  logic [NR-1:0]   gnt, lck;
  logic [2:0]      slot;
  logic [NB-1:0]   busy;

  int checks = 0, errors = 0, cyc = 0;
  int last_g[NB];
  int res[NB];
  logic [NR-1:0] fg, fl;
  int pend_b[NR];
  bit pend[NR];
  bit done = 0;

  always #10 clk = ~clk;

  bank_interlock_arb #(.NUM_BANKS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .bank_i(bank),
    .grant_o(gnt), .lockout_o(lck), .slot_o(slot), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit bank_free(int b);
    return (last_g[b] < 0) || (cyc - last_g[b] >= 8);
  endfunction

  function automatic int exp_busy();
    int v = 0;
    for (int b = 0; b < NB; b++)
      if (last_g[b] >= 0 && cyc - last_g[b] >= 1 && cyc - last_g[b] <= 7) v |= (1 << b);
    return v;
  endfunction

  task automatic model_reset();
    cyc = 0;
    for (int b = 0; b < NB; b++) begin last_g[b] = -1; res[b] = -1; end
  endtask

  // one clock: drive, sample mid-low phase, compare, advance model
  task automatic step(input logic [NR-1:0] rq, input logic [NR*BW-1:0] bk);
    int s, r, b;
    logic [NR-1:0] eg, el;
    req = rq; bank = bk;
    #2;
    s = cyc % 8; eg = '0; el = '0; r = -1; b = 0;
    if (s % 2 == 0 && rq[s/2]) begin
      r = s / 2;
      b = int'(bk[r*BW +: BW]);
      if (b < NB && bank_free(b) && !(res[b] >= 0 && res[b] < r)) eg[r] = 1'b1;
      else el[r] = 1'b1;
    end
    chk("R1 slot", int'(slot), s);
    chk("R4 busy", int'(busy), exp_busy());
    chk("R2/R3/R7 grant", int'(gnt), int'(eg));
    chk("R2/R5/R10 lockout", int'(lck), int'(el));
    if (r >= 0) begin
      if (eg[r]) begin
        last_g[b] = cyc;
        if (res[b] == r) res[b] = -1;
      end else if (b < NB && (res[b] < 0 || r < res[b])) begin
        res[b] = r;
      end
      fg[r] = gnt[r]; fl[r] = lck[r];
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic frame(input logic [NR-1:0] m, input int b0, input int b1, input int b2, input int b3);
    logic [NR*BW-1:0] bk;
    bk = {BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
    fg = '0; fl = '0;
    for (int s = 0; s < 8; s++) step(m, bk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req = '0;
    #2;
    chk("R11 busy cleared", int'(busy), 0);
    chk("R1 slot in reset", int'(slot), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();

    // R3: free bank granted
    frame(4'b1000, 0, 0, 0, 3);
    chk("R3 cpu1 free bank", int'(fg[3]), 1);
    // R5 busy lockout, R7 reserved-for-DMA bank blocks cpu1 while free
    frame(4'b1101, 3, 0, 3, 3);
    chk("R5 dma on busy bank", int'(fl[0]), 1);
    chk("R5 cpu0 on busy bank", int'(fl[2]), 1);
    chk("R7 cpu1 blocked by reservation", int'(fl[3]), 1);
    // R6 DMA retry wins, R9 disjoint bank granted alongside
    frame(4'b0011, 3, 1, 0, 0);
    chk("R6 dma retry granted", int'(fg[0]), 1);
    chk("R9 io disjoint bank", int'(fg[1]), 1);
    // R8 reservation gone: cpu0 gets bank 3
    frame(4'b0100, 0, 0, 3, 0);
    chk("R8 cpu0 after release", int'(fg[2]), 1);
    // R9 four disjoint banks in one major cycle
    frame(4'b1111, 0, 1, 2, 4);
    chk("R9 all disjoint granted", int'(fg), 15);
    // R10 out-of-range codes
    frame(4'b0010, 0, 6, 0, 0);
    chk("R10 bank 6 locked", int'(fl[1]), 1);
    frame(4'b0001, 7, 0, 0, 0);
    chk("R10 bank 7 locked", int'(fl[0]), 1);
    chk("R10 no busy change", int'(busy), 0);
    // R4 same slot next major cycle
    frame(4'b1000, 0, 0, 0, 5);
    frame(4'b1000, 0, 0, 0, 5);
    chk("R4 regrant after eight clocks", int'(fg[3]), 1);
    // R6 lower holder, then in-frame lockout reserves for io
    frame(4'b0011, 2, 2, 0, 0);
    chk("R5 io same-frame collision", int'(fl[1]), 1);
    frame(4'b0010, 0, 2, 0, 0);
    chk("R6 io retry granted", int'(fg[1]), 1);
    // R6 io holds bank 4 against cpu0
    frame(4'b1000, 0, 0, 0, 4);
    frame(4'b0110, 0, 4, 4, 0);
    frame(4'b0100, 0, 0, 4, 0);
    chk("R6 cpu0 blocked by io hold", int'(fl[2]), 1);
    frame(4'b0010, 0, 4, 0, 0);
    chk("R8 io owner granted", int'(fg[1]), 1);
    // R7 higher-priority granted over a weaker reservation
    frame(4'b1001, 1, 0, 0, 1);
    chk("R5 cpu1 locked on bank 1", int'(fl[3]), 1);
    frame(4'b1010, 0, 1, 0, 1);
    chk("R7 io granted over cpu1 hold", int'(fg[1]), 1);
    frame(4'b1000, 0, 0, 0, 1);
    chk("R8 cpu1 finally granted", int'(fg[3]), 1);

    // random traffic with retries
    for (int k = 0; k < NR; k++) pend[k] = 0;
    for (int f = 0; f < 1500; f++) begin
      logic [NR-1:0] m;
      int bb[NR];
      bit dma_retry;
      m = '0;
      dma_retry = pend[0];
      for (int r = 0; r < NR; r++) begin
        if (pend[r]) begin m[r] = 1'b1; bb[r] = pend_b[r]; end
        else begin m[r] = ($urandom % 10) < 6; bb[r] = $urandom % 8; end
      end
      frame(m, bb[0], bb[1], bb[2], bb[3]);
      if (dma_retry) chk("R6 random dma retry", int'(fg[0]), 1);
      for (int r = 0; r < NR; r++) begin
        pend[r] = m[r] && fl[r] && (bb[r] < NB);
        pend_b[r] = bb[r];
      end
    end
    // drain: only retries run; every lockout must end in a grant
    for (int f = 0; f < 12; f++) begin
      logic [NR-1:0] m;
      for (int r = 0; r < NR; r++) m[r] = pend[r];
      frame(m, pend_b[0], pend_b[1], pend_b[2], pend_b[3]);
      for (int r = 0; r < NR; r++) if (pend[r] && fg[r]) pend[r] = 0;
    end
    for (int r = 0; r < NR; r++) chk("R6 lockout eventually granted", int'(pend[r]), 0);

    // R11: reservation and busy cleared by reset
    frame(4'b0000, 0, 0, 0, 0);
    frame(4'b0010, 0, 1, 0, 0);
    frame(4'b0101, 1, 0, 1, 0);
    chk("R7 cpu0 blocked before reset", int'(fl[2]), 1);
    do_reset();
    frame(4'b0100, 0, 0, 1, 0);
    chk("R11 cpu0 granted after reset", int'(fg[2]), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule